// File: doc/BRIEF.md
# Timer Capture/Compare Unit

A 16-bit timebase with a power-of-two prescaler and a modulo limit, shared by a configurable number of channels. Each channel can latch the count on an input edge, act on an output pin when the count reaches a programmed value, or produce an edge-aligned or centre-aligned pulse-width waveform.

Software loads a channel's 16-bit value one byte at a time into a holding register. The block moves the held word into the channel's working register at a moment that depends on the channel mode. In compare mode the move happens on the next count step, so a value computed relative to the running count takes effect at once, with no need to stop or reset the counter. In the waveform modes the move happens only at the period boundary, so a duty cycle never changes in the middle of a period.

Sticky channel and overflow flags report events until software clears them with a strobe. The working register of each channel can be read on a port, which gives both the captured count and the transferred compare value.

Top module: `tmr_capcmp_unit`

## Requirements
- R1: After reset the count, overflow flag, channel flags, channel pins and channel values are all 0. With a modulo of 0 the count runs 0 to 0xFFFF, then returns to 0, and the step from 0xFFFF to 0 sets the overflow flag.
- R2: A clock select of 2'b00 holds the count and clears the prescaler. Any other value advances the count by one every 2^preSel clock cycles, the first step coming 2^preSel cycles after the counter is started.
- R3: With a nonzero modulo M (edge counting), the count runs 0..M and then steps to 0, and that step sets the overflow flag.
- R4: In compare mode (center select 0, chModeSel 2'b01), a completed byte pair is copied into the channel value on the first count step after the low-byte write, and not earlier.
- R5: A byte pair is complete only when a low-byte write follows a high-byte write. A low-byte write with no high byte pending is ignored, and a second high-byte write replaces the first and restarts the pair.
- R6: In compare mode the channel flag is set on the same edge at which the count steps onto the channel value.
- R7: On a compare match the pin follows chEdgeSel: 2'b01 toggles it, 2'b10 drives it to 0, 2'b11 drives it to 1.
- R8: In capture mode (chModeSel 2'b00) the count present at a selected edge of capIn is latched into the channel value and the flag is set. chEdgeSel 2'b01 selects the rising edge, 2'b10 the falling edge and 2'b11 both. An edge that is not selected changes neither the value nor the flag.
- R9: Flags stay set until their clear strobe. A set event and a clear strobe on the same edge leave the flag set.
- R10: In edge waveform mode (chModeSel 2'b1x) the held word moves into the channel value only on the count step from M-1 to M. The pin is 1 while the count is below the channel value when chEdgeSel[0]=0, and the inverse of that when chEdgeSel[0]=1.
- R11: With center select 1, all channels are centre-aligned and the count runs up from 0 to M and then down to 0. The overflow flag sets on the step to 0, the held word transfers on the upward step into M, and the pin is 1 while the count is below the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clkSel | input | 2 | 2'b00 stops the counter; any other value runs it |
| preSel | input | 3 | Prescale exponent: one step per 2^preSel cycles |
| pwmCenter | input | 1 | 1 selects centre-aligned waveforms on all channels |
| modWrite | input | 1 | Strobe that loads modValue into the modulo register |
| modValue | input | 16 | Modulo value; 0 means 0xFFFF |
| ovfClear | input | 1 | Clear strobe for the overflow flag |
| chModeSel | input | 2*NUM_CH | Per-channel mode bits |
| chEdgeSel | input | 2*NUM_CH | Per-channel edge or pin-action bits |
| chWrHi | input | NUM_CH | Per-channel high-byte write strobe |
| chWrLo | input | NUM_CH | Per-channel low-byte write strobe |
| wrData | input | 8 | Byte written by the strobes |
| capIn | input | NUM_CH | Per-channel capture input, synchronous to clk |
| chFlagClear | input | NUM_CH | Per-channel flag clear strobe |
| count | output | 16 | Current count |
| ovfFlag | output | 1 | Sticky overflow flag |
| chFlag | output | NUM_CH | Sticky channel flags |
| chPin | output | NUM_CH | Channel pin outputs |
| chValue | output | 16*NUM_CH | Working register of each channel |

## Verification
A flag can be set by its own event and cleared by software on the same edge. This is provoked for both the overflow flag and a compare flag: the bench waits until the count stands one step short of the wrap or the match, then raises the clear strobe for exactly that edge. The result is judged at the ports, where the flag must read 1 afterwards. A second collision, a buffer completion landing next to a transfer point, is driven with a slow prescaler so that the value port shows the transfer waiting for the next count step.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = CNT_W / 2;

  typedef enum logic [1:0] {
    KIND_CAPTURE,
    KIND_COMPARE,
    KIND_EDGE_PWM,
    KIND_CENTER_PWM
  } chKind_t;

  // strobes from the counter control to the channel datapath
  typedef struct packed {
    logic             tick;     // count steps on this edge
    logic             pwmLoad;  // waveform buffer transfer point
    logic [CNT_W-1:0] cntNow;   // count before the edge
    logic [CNT_W-1:0] cntNext;  // count after the edge when tick
  } cntStrobe_t;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       clkSel,
  input  logic [PRE_W-1:0] preSel,
  input  logic             pwmCenter,
  input  logic             modWrite,
  input  logic [CNT_W-1:0] modValue,
  input  logic             ovfClear,
  output cntStrobe_t       strb,
  output logic [CNT_W-1:0] cnt,
  output logic             ovfFlag
);
  localparam int PRE_CNT_W = (1 << PRE_W) - 1;

  logic [PRE_CNT_W-1:0] preCnt;
  logic [PRE_CNT_W-1:0] preMask;
  logic [CNT_W-1:0]     modReg;
  logic [CNT_W-1:0]     modEff;
  logic [CNT_W-1:0]     cntNext;
  logic                 dirUp;
  logic                 dirNext;
  logic                 wrapEvt;
  logic                 running;
  logic                 tick;

  assign running = (clkSel != 2'b00);
  assign preMask = PRE_CNT_W'((32'd1 << preSel) - 32'd1);
  assign tick    = running && (preCnt >= preMask);
  assign modEff  = (modReg == '0) ? '1 : modReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        preCnt <= '0;
    else if (!running || tick) preCnt <= '0;
    else              preCnt <= preCnt + PRE_CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         modReg <= '0;
    else if (modWrite) modReg <= modValue;
  end

  always_comb begin
    cntNext = cnt;
    dirNext = dirUp;
    wrapEvt = 1'b0;
    if (pwmCenter) begin
      if (dirUp) begin
        if (cnt >= modEff) begin
          dirNext = 1'b0;
          cntNext = cnt - CNT_W'(1);
        end else begin
          cntNext = cnt + CNT_W'(1);
        end
      end else begin
        if (cnt <= CNT_W'(1)) begin
          cntNext = '0;
          dirNext = 1'b1;
          wrapEvt = 1'b1;
        end else begin
          cntNext = cnt - CNT_W'(1);
        end
      end
    end else begin
      dirNext = 1'b1;
      if (cnt >= modEff) begin
        cntNext = '0;
        wrapEvt = 1'b1;
      end else begin
        cntNext = cnt + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      dirUp <= 1'b1;
    end else if (tick) begin
      cnt   <= cntNext;
      dirUp <= dirNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 ovfFlag <= 1'b0;
    else if (tick && wrapEvt)  ovfFlag <= 1'b1;
    else if (ovfClear)         ovfFlag <= 1'b0;
  end

  assign strb.tick    = tick;
  assign strb.pwmLoad = tick && dirUp && (cnt == modEff - CNT_W'(1));
  assign strb.cntNow  = cnt;
  assign strb.cntNext = cntNext;

  // R2: a stopped counter holds its value
  a_r2_stop_holds: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == 2'b00) |=> $stable(cnt));

  // R3: an edge-counting step never lands above the modulo limit
  a_r3_within_modulo: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !pwmCenter) |=> (cnt <= $past(modEff)));

  // R1: the overflow flag rises only together with a return to zero
  a_r1_ovf_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> (cnt == '0));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cntStrobe_t        strb,
  input  logic              pwmCenter,
  input  logic [1:0]        modeSel,
  input  logic [1:0]        edgeSel,
  input  logic              wrHi,
  input  logic              wrLo,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              capIn,
  input  logic              flagClear,
  output logic              pinOut,
  output logic              flag,
  output logic [CNT_W-1:0]  value
);
  chKind_t           kind;
  logic [BYTE_W-1:0] bufHi;
  logic [BYTE_W-1:0] bufLo;
  logic [CNT_W-1:0]  bufWord;
  logic              armed;
  logic              full;
  logic              isCap;
  logic              isOc;
  logic              isPwm;
  logic              doLoad;
  logic              match;
  logic              prevIn;
  logic              captureHit;
  logic [CNT_W-1:0]  dutyVal;

  always_comb begin
    if (pwmCenter)              kind = KIND_CENTER_PWM;
    else if (modeSel == 2'b00)  kind = KIND_CAPTURE;
    else if (modeSel == 2'b01)  kind = KIND_COMPARE;
    else                        kind = KIND_EDGE_PWM;
  end

  assign isCap   = (kind == KIND_CAPTURE);
  assign isOc    = (kind == KIND_COMPARE);
  assign isPwm   = (kind == KIND_EDGE_PWM) || (kind == KIND_CENTER_PWM);
  assign bufWord = {bufHi, bufLo};
  assign doLoad  = full && ((isOc && strb.tick) || (isPwm && strb.pwmLoad));
  assign match   = strb.tick && (strb.cntNext == value);
  assign captureHit = isCap && ((edgeSel[0] && capIn && !prevIn) ||
                                (edgeSel[1] && !capIn && prevIn));
  assign dutyVal = doLoad ? bufWord : value;

  // two-byte holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufHi <= '0;
      bufLo <= '0;
      armed <= 1'b0;
      full  <= 1'b0;
    end else if (wrHi) begin
      bufHi <= wrData;
      armed <= 1'b1;
      full  <= 1'b0;
    end else if (wrLo && armed) begin
      bufLo <= wrData;
      armed <= 1'b0;
      full  <= 1'b1;
    end else if (doLoad) begin
      full  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           value <= '0;
    else if (doLoad)     value <= bufWord;
    else if (captureHit) value <= strb.cntNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevIn <= 1'b0;
    else       prevIn <= capIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         flag <= 1'b0;
    else if (captureHit || (!isCap && match)) flag <= 1'b1;
    else if (flagClear)                flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinOut <= 1'b0;
    end else if (isOc && match) begin
      case (edgeSel)
        2'b01:   pinOut <= !pinOut;
        2'b10:   pinOut <= 1'b0;
        2'b11:   pinOut <= 1'b1;
        default: pinOut <= pinOut;
      endcase
    end else if (isPwm && strb.tick) begin
      pinOut <= (strb.cntNext < dutyVal) ^ edgeSel[0];
    end
  end

  // R4: in compare mode the working value only moves on a count step
  a_r4_oc_load_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    (isOc && $past(isOc) && !$stable(value)) |-> $past(strb.tick));

  // R10: in waveform modes the working value only moves at the period boundary
  a_r10_pwm_load_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    (isPwm && $past(isPwm) && !$stable(value)) |-> $past(strb.pwmLoad));

  // R8: a capture always leaves the flag set
  a_r8_capture_flags: assert property (@(posedge clk) disable iff (!rstN)
    (isCap && $past(isCap) && !$stable(value)) |-> flag);

  // R9: a set flag survives until a clear strobe
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ($past(flag) && !$past(flagClear)) |-> flag);
endmodule

// File: rtl/tmr_capcmp_unit.sv
module tmr_capcmp_unit
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int PRE_W  = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [1:0]              clkSel,
  input  logic [PRE_W-1:0]        preSel,
  input  logic                    pwmCenter,
  input  logic                    modWrite,
  input  logic [CNT_W-1:0]        modValue,
  input  logic                    ovfClear,
  input  logic [2*NUM_CH-1:0]     chModeSel,
  input  logic [2*NUM_CH-1:0]     chEdgeSel,
  input  logic [NUM_CH-1:0]       chWrHi,
  input  logic [NUM_CH-1:0]       chWrLo,
  input  logic [BYTE_W-1:0]       wrData,
  input  logic [NUM_CH-1:0]       capIn,
  input  logic [NUM_CH-1:0]       chFlagClear,
  output logic [CNT_W-1:0]        count,
  output logic                    ovfFlag,
  output logic [NUM_CH-1:0]       chFlag,
  output logic [NUM_CH-1:0]       chPin,
  output logic [CNT_W*NUM_CH-1:0] chValue
);
  cntStrobe_t strb;

  tmr_counter #(.PRE_W(PRE_W)) u_counter (
    .clk      (clk),
    .rstN     (rstN),
    .clkSel   (clkSel),
    .preSel   (preSel),
    .pwmCenter(pwmCenter),
    .modWrite (modWrite),
    .modValue (modValue),
    .ovfClear (ovfClear),
    .strb     (strb),
    .cnt      (count),
    .ovfFlag  (ovfFlag)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tmr_channel u_channel (
      .clk      (clk),
      .rstN     (rstN),
      .strb     (strb),
      .pwmCenter(pwmCenter),
      .modeSel  (chModeSel[2*c +: 2]),
      .edgeSel  (chEdgeSel[2*c +: 2]),
      .wrHi     (chWrHi[c]),
      .wrLo     (chWrLo[c]),
      .wrData   (wrData),
      .capIn    (capIn[c]),
      .flagClear(chFlagClear[c]),
      .pinOut   (chPin[c]),
      .flag     (chFlag[c]),
      .value    (chValue[CNT_W*c +: CNT_W])
    );
  end
endmodule

// File: tb/tb_tmr_capcmp_unit.sv
module tb_tmr_capcmp_unit;
  localparam int NCH = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  clkSel = 2'b00;
  logic [2:0]  preSel = 3'd0;
  logic        pwmCenter = 1'b0;
  logic        modWrite = 1'b0;
  logic [15:0] modValue = 16'd0;
  logic        ovfClear = 1'b0;
  logic [3:0]  chModeSel = 4'd0;
  logic [3:0]  chEdgeSel = 4'd0;
  logic [1:0]  chWrHi = 2'd0;
  logic [1:0]  chWrLo = 2'd0;
  logic [7:0]  wrData = 8'd0;
  logic [1:0]  capIn = 2'd0;
  logic [1:0]  chFlagClear = 2'd0;
  logic [15:0] count;
  logic        ovfFlag;
  logic [1:0]  chFlag;
  logic [1:0]  chPin;
  logic [31:0] chValue;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int expA, expB, target, mVal, pVal, vVal, nVal, kVal, tgl;

  always #4 clk = ~clk;

  tmr_capcmp_unit #(.NUM_CH(NCH), .PRE_W(3)) dut (
    .clk(clk), .rstN(rstN), .clkSel(clkSel), .preSel(preSel),
    .pwmCenter(pwmCenter), .modWrite(modWrite), .modValue(modValue),
    .ovfClear(ovfClear), .chModeSel(chModeSel), .chEdgeSel(chEdgeSel),
    .chWrHi(chWrHi), .chWrLo(chWrLo), .wrData(wrData), .capIn(capIn),
    .chFlagClear(chFlagClear), .count(count), .ovfFlag(ovfFlag),
    .chFlag(chFlag), .chPin(chPin), .chValue(chValue)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; clkSel = 2'b00; preSel = 3'd0; pwmCenter = 1'b0;
    modWrite = 1'b0; modValue = 16'd0; ovfClear = 1'b0;
    chModeSel = 4'd0; chEdgeSel = 4'd0; chWrHi = 2'd0; chWrLo = 2'd0;
    wrData = 8'd0; capIn = 2'd0; chFlagClear = 2'd0;
    step(2);
    rstN = 1'b1;
    step(1);
  endtask

  task automatic setMod(input int m);
    modValue = 16'(m); modWrite = 1'b1; step(1); modWrite = 1'b0;
  endtask

  task automatic writeBuf(input int ch, input int v);
    wrData = 8'(v >> 8); chWrHi[ch] = 1'b1; step(1); chWrHi[ch] = 1'b0;
    wrData = 8'(v);      chWrLo[ch] = 1'b1; step(1); chWrLo[ch] = 1'b0;
  endtask

  task automatic waitCount(input int v);
    for (int i = 0; i < 70000 && count != 16'(v); i++) step(1);
  endtask

  task automatic clrFlag(input int ch);
    chFlagClear[ch] = 1'b1; step(1); chFlagClear[ch] = 1'b0;
  endtask

  function automatic int chVal(input int ch);
    return int'(chValue[16*ch +: 16]);
  endfunction

  // closed-form count after k steps with an edge-counting modulo m
  function automatic int modelCount(input int k, input int m);
    return k % (m + 1);
  endfunction

  function automatic int modelToggles(input int k, input int v, input int m);
    if (k < v) return 0;
    return (k - v) / (m + 1) + 1;
  endfunction

  initial begin
    #(8 * 195000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    doReset();
    // R1 reset state
    chk("R1 reset count", count, 0);
    chk("R1 reset ovf", ovfFlag, 0);
    chk("R1 reset flags", chFlag, 0);
    chk("R1 reset pins", chPin, 0);
    chk("R1 reset values", chValue, 0);

    // R2 stop and prescale
    step(20);
    chk("R2 stopped count", count, 0);
    preSel = 3'd2; clkSel = 2'b01;
    step(12);
    chk("R2 prescale 4 count", count, 3);
    step(3);
    chk("R2 between steps", count, 3);

    // R3 modulo wrap and R9 overflow clear collision
    doReset();
    setMod(9);
    clkSel = 2'b10;
    step(9);
    chk("R3 count at modulo", count, 9);
    chk("R3 ovf before wrap", ovfFlag, 0);
    step(1);
    chk("R3 wrap to zero", count, 0);
    chk("R3 ovf after wrap", ovfFlag, 1);
    ovfClear = 1'b1; step(1); ovfClear = 1'b0;
    chk("R9 ovf cleared", ovfFlag, 0);
    waitCount(9);
    ovfClear = 1'b1; step(1); ovfClear = 1'b0;
    chk("R9 set beats clear count", count, 0);
    chk("R9 set beats clear ovf", ovfFlag, 1);

    // R1 free-running wrap
    doReset();
    clkSel = 2'b01;
    step(65535);
    chk("R1 count at 0xFFFF", count, 16'hFFFF);
    chk("R1 no ovf yet", ovfFlag, 0);
    step(1);
    chk("R1 wrap count", count, 0);
    chk("R1 wrap ovf", ovfFlag, 1);

    // R4 compare transfer waits for a count step
    doReset();
    chModeSel = 4'b0001;
    preSel = 3'd2; clkSel = 2'b01;
    step(4);
    chk("R2 first step after 4", count, 1);
    writeBuf(0, 16'h1234);
    step(1);
    chk("R4 no transfer before step", chVal(0), 0);
    step(1);
    chk("R4 transfer on step", chVal(0), 16'h1234);

    // R5 byte pairing
    wrData = 8'h77; chWrLo[0] = 1'b1; step(1); chWrLo[0] = 1'b0;
    step(8);
    chk("R5 lone low ignored", chVal(0), 16'h1234);
    wrData = 8'hAB; chWrHi[0] = 1'b1; step(1); chWrHi[0] = 1'b0;
    step(8);
    chk("R5 lone high no transfer", chVal(0), 16'h1234);
    writeBuf(0, 16'hCDEF);
    step(8);
    chk("R5 second high restarts", chVal(0), 16'hCDEF);

    // R6 R7 compare match and pin actions
    doReset();
    chModeSel = 4'b0001; chEdgeSel = 4'b0001;
    writeBuf(0, 20);
    clkSel = 2'b01;
    waitCount(19);
    chk("R6 no flag before match", chFlag[0], 0);
    chk("R7 pin before toggle", chPin[0], 0);
    step(1);
    chk("R6 flag at match", chFlag[0], 1);
    chk("R7 toggle pin", chPin[0], 1);
    clrFlag(0);
    chk("R9 channel flag cleared", chFlag[0], 0);
    chEdgeSel = 4'b0010;
    target = int'(count) + 10;
    writeBuf(0, target);
    waitCount(target - 1);
    chk("R6 relative no early flag", chFlag[0], 0);
    step(1);
    chk("R6 relative match flag", chFlag[0], 1);
    chk("R7 clear pin", chPin[0], 0);
    clrFlag(0);
    chEdgeSel = 4'b0011;
    target = int'(count) + 8;
    writeBuf(0, target);
    waitCount(target - 1);
    chFlagClear[0] = 1'b1; step(1); chFlagClear[0] = 1'b0;
    chk("R9 match beats clear", chFlag[0], 1);
    chk("R7 set pin", chPin[0], 1);

    // R8 capture edges on channel 1
    chEdgeSel[3:2] = 2'b01;
    step(3);
    expA = int'(count);
    capIn[1] = 1'b1; step(1);
    chk("R8 rising capture value", chVal(1), expA);
    chk("R8 rising capture flag", chFlag[1], 1);
    clrFlag(1);
    step(4);
    capIn[1] = 1'b0; step(1);
    chk("R8 unselected fall value", chVal(1), expA);
    chk("R8 unselected fall flag", chFlag[1], 0);
    chEdgeSel[3:2] = 2'b11;
    step(3);
    expB = int'(count);
    capIn[1] = 1'b1; step(1);
    chk("R8 both edges rise", chVal(1), expB);
    clrFlag(1);
    step(4);
    expB = int'(count);
    capIn[1] = 1'b0; step(1);
    chk("R8 both edges fall", chVal(1), expB);
    chk("R8 both edges flag", chFlag[1], 1);

    // R10 edge waveform
    doReset();
    setMod(9);
    chModeSel = 4'b0010; chEdgeSel = 4'b0000;
    writeBuf(0, 4);
    clkSel = 2'b01;
    waitCount(8);
    chk("R10 no transfer mid period", chVal(0), 0);
    step(1);
    chk("R10 transfer at boundary", chVal(0), 4);
    chk("R10 pin low at modulo", chPin[0], 0);
    waitCount(2);
    chk("R10 pin high below duty", chPin[0], 1);
    waitCount(6);
    chk("R10 pin low above duty", chPin[0], 0);
    writeBuf(0, 7);
    chk("R10 held until boundary", chVal(0), 4);
    step(1);
    chk("R10 new duty loaded", chVal(0), 7);
    waitCount(5);
    chk("R10 new duty high", chPin[0], 1);
    waitCount(8);
    chk("R10 new duty low", chPin[0], 0);
    chEdgeSel = 4'b0001;
    step(1);
    chk("R10 inverted polarity", chPin[0], 1);

    // R11 centre-aligned
    doReset();
    pwmCenter = 1'b1;
    setMod(4);
    writeBuf(0, 2);
    clkSel = 2'b01;
    step(3);
    chk("R11 up count", count, 3);
    chk("R11 no early transfer", chVal(0), 0);
    step(1);
    chk("R11 top count", count, 4);
    chk("R11 transfer at top", chVal(0), 2);
    chk("R11 pin low at top", chPin[0], 0);
    step(2);
    chk("R11 down count", count, 2);
    chk("R11 pin low at duty", chPin[0], 0);
    step(1);
    chk("R11 pin high below duty", chPin[0], 1);
    chk("R11 no ovf yet", ovfFlag, 0);
    step(1);
    chk("R11 bottom count", count, 0);
    chk("R11 ovf at bottom", ovfFlag, 1);
    step(1);
    chk("R11 up again", count, 1);

    // random trials: R2 R3 R6 R7
    for (int t = 0; t < 16; t++) begin
      mVal = 3 + int'($urandom % 30);
      pVal = int'($urandom % 3);
      vVal = 2 + int'($urandom % (mVal - 1));
      nVal = 1 + int'($urandom % (4 * (mVal + 1) << pVal));
      doReset();
      setMod(mVal);
      preSel = 3'(pVal);
      chModeSel = 4'b0001; chEdgeSel = 4'b0001;
      writeBuf(0, vVal);
      clkSel = 2'b11;
      step(nVal);
      kVal = nVal >> pVal;
      tgl = modelToggles(kVal, vVal, mVal);
      chk("R2 R3 random count", count, modelCount(kVal, mVal));
      chk("R3 random ovf", ovfFlag, (kVal >= mVal + 1) ? 1 : 0);
      chk("R6 random flag", chFlag[0], (kVal >= vVal) ? 1 : 0);
      chk("R7 random pin", chPin[0], tgl & 1);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule